// File: doc/BRIEF.md
# Byte-to-Word Host Bus Bridge

This block lets a host with an 8-bit data bus reach an internal memory and register space that is organised as 16-bit words. Each host access carries a word address, a byte-select line (wired from the host's lowest address bit) and a read/write flag, qualified by a one-cycle strobe. The host's byte lanes feed both halves of the internal word. Host writes are collected into full internal word writes. Internal word reads are handed back to the host one byte at a time.

Three static strap inputs set how the bridge behaves. The polarity strap sets which level of the byte-select line means the upper byte. The trigger strap sets which byte access starts the internal 16-bit cycle. The zero-wait strap picks either handshaked operation, with an acknowledge pulse to the host, or zero-wait operation, where no acknowledge is given. In handshaked mode the launching byte differs between reads and writes. In zero-wait mode the same byte launches both. The byte that does not launch a transfer is served from a local holding byte (writes) or a read buffer (reads), with no internal cycle.

An internal cycle raises a request together with the address, the direction and the merged write word. It keeps all of them steady until the internal side returns ready.

Top module: `byte_word_bridge`

## Requirements
- R1: With the polarity strap at 1, byte-select 0 addresses the upper byte (bits 15:8) and byte-select 1 the lower byte (bits 7:0). With the strap at 0 the mapping is swapped.
- R2: In handshaked mode (zero-wait strap 1), a trigger strap of 1 makes an upper-byte read and a lower-byte write launch the internal cycle. A trigger strap of 0 makes a lower-byte read and an upper-byte write launch it.
- R3: In zero-wait mode (zero-wait strap 0), the lower byte launches the internal cycle for both directions when the trigger strap is 1, and the upper byte does so when it is 0.
- R4: A non-launching write stores its byte in a holding register and starts no internal cycle. A launching write issues one internal write to its word address, with its own byte in its own lane and the held byte in the other lane.
- R5: A launching read issues one internal read. Its requested byte appears on the host read data at the clock edge where ready is accepted, and the other byte of the word is kept in a read buffer.
- R6: A non-launching read returns the read buffer contents on the host read data one clock after its strobe, and starts no internal cycle.
- R7: Once raised, the internal request stays high, with address, direction and write word unchanged, until ready is sampled high. It drops on the clock edge that accepts ready.
- R8: In handshaked mode the acknowledge is a single-cycle pulse. For a non-launching access it is high in the cycle after the strobe edge. For a launching access it is high in the cycle after ready is accepted.
- R9: In zero-wait mode the acknowledge is never asserted.
- R10: A strobe that arrives while an internal request is pending is ignored: it changes neither the holding byte nor the read buffer, and it produces no acknowledge and no further internal cycle.
- R11: Reset drops any pending internal request and the acknowledge, and clears the holding byte, the read buffer and the host read data to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapPolarity | input | 1 | Byte-select polarity strap |
| strapTrigger | input | 1 | Launching-byte select strap |
| strapZeroWait | input | 1 | 1 = handshaked, 0 = zero-wait |
| hostStrobe | input | 1 | One-cycle access strobe |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostByteSel | input | 1 | Byte-select line (host address bit 0) |
| hostWordAddr | input | ADDR_W | Word address (upper host address bits) |
| hostWrData | input | BYTE_W | Host write byte |
| hostRdData | output | BYTE_W | Host read byte |
| hostAck | output | 1 | Acknowledge pulse, handshaked mode only |
| intReq | output | 1 | Internal cycle request |
| intWrite | output | 1 | Internal cycle direction, 1 = write |
| intAddr | output | ADDR_W | Internal word address |
| intWrData | output | 2*BYTE_W | Internal write word |
| intRdData | input | 2*BYTE_W | Internal read word |
| intReady | input | 1 | Internal cycle completion |

## Verification
If the lane decode is wrong, an internal cycle fires on the wrong access, or on none. This is visible on the request line one clock after the strobe. A corrupted holding byte or read buffer stays hidden until the next launching write or non-launching read. It then shows as a wrong byte lane in the internal write word, or a wrong host read byte, one clock after that strobe. A control state stuck in waiting shows as a missing acknowledge, or as a request that stays high after ready. Any of these appears within two clocks of the access that exposes it.

// File: rtl/bwb_pkg.sv
package bwb_pkg;

  // Single-cycle strobes from control to datapath
  typedef struct packed {
    logic acceptHold;  // store non-launching write byte
    logic serveBuf;    // return read buffer to host
    logic launch;      // capture internal cycle parameters
    logic complete;    // internal cycle accepted ready
  } bwb_strobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } bwb_state_t;

endpackage

// File: rtl/bwb_lane_decode.sv
module bwb_lane_decode (
  input  logic strapPolarity,
  input  logic strapTrigger,
  input  logic strapZeroWait,
  input  logic hostByteSel,
  input  logic hostWrite,
  output logic laneUpper,
  output logic launches
);

  logic launchOnUpper;

  // Polarity strap: 1 means a low select addresses the upper byte
  assign laneUpper = strapPolarity ? ~hostByteSel : hostByteSel;

  // Handshaked mode: the read and write launching bytes are opposite.
  // Zero-wait mode: one byte launches both directions.
  always_comb begin
    if (strapZeroWait) begin
      launchOnUpper = hostWrite ? ~strapTrigger : strapTrigger;
    end else begin
      launchOnUpper = ~strapTrigger;
    end
  end

  assign launches = (laneUpper == launchOnUpper);

endmodule

// File: rtl/bwb_ctrl.sv
module bwb_ctrl
  import bwb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        strapZeroWait,
  input  logic        hostStrobe,
  input  logic        hostWrite,
  input  logic        launches,
  input  logic        intReady,
  output bwb_strobe_t strb,
  output logic        intReq,
  output logic        hostAck
);

  bwb_state_t state;

  always_comb begin
    strb = '0;
    if (state == ST_IDLE) begin
      if (hostStrobe) begin
        if (launches) begin
          strb.launch = 1'b1;
        end else if (hostWrite) begin
          strb.acceptHold = 1'b1;
        end else begin
          strb.serveBuf = 1'b1;
        end
      end
    end else begin
      strb.complete = intReady;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      hostAck <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (strb.launch) state <= ST_WAIT;
        ST_WAIT: if (strb.complete) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      hostAck <= strapZeroWait & (strb.acceptHold | strb.serveBuf | strb.complete);
    end
  end

  assign intReq = (state == ST_WAIT);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    intReq && !intReady |=> intReq); // R7

  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    intReq && intReady |=> !intReq); // R7

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> !hostAck); // R8

  AST_ACK_AFTER_READY: assert property (@(posedge clk) disable iff (!rstN)
    strapZeroWait && intReq && intReady |=> hostAck); // R8

  AST_ZW_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !strapZeroWait && !$past(strapZeroWait) |-> !hostAck); // R9

  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    intReq && !intReady |=> !hostAck); // R10

endmodule

// File: rtl/bwb_datapath.sv
module bwb_datapath
  import bwb_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  bwb_strobe_t       strb,
  input  logic              laneUpper,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostWordAddr,
  input  logic [BYTE_W-1:0] hostWrData,
  input  logic [WORD_W-1:0] intRdData,
  output logic [BYTE_W-1:0] hostRdData,
  output logic [ADDR_W-1:0] intAddr,
  output logic              intWrite,
  output logic [WORD_W-1:0] intWrData
);

  logic [BYTE_W-1:0] holdByte;
  logic [BYTE_W-1:0] rdBuf;
  logic              pendUpper;
  logic [BYTE_W-1:0] rdUpper;
  logic [BYTE_W-1:0] rdLower;

  assign rdUpper = intRdData[WORD_W-1:BYTE_W];
  assign rdLower = intRdData[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdByte   <= '0;
      rdBuf      <= '0;
      hostRdData <= '0;
      intAddr    <= '0;
      intWrite   <= 1'b0;
      intWrData  <= '0;
      pendUpper  <= 1'b0;
    end else begin
      if (strb.acceptHold) holdByte <= hostWrData;
      if (strb.serveBuf) hostRdData <= rdBuf;
      if (strb.launch) begin
        intAddr   <= hostWordAddr;
        intWrite  <= hostWrite;
        pendUpper <= laneUpper;
        intWrData <= laneUpper ? {hostWrData, holdByte} : {holdByte, hostWrData};
      end
      if (strb.complete && !intWrite) begin
        hostRdData <= pendUpper ? rdUpper : rdLower;
        rdBuf      <= pendUpper ? rdLower : rdUpper;
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.acceptHold, strb.serveBuf, strb.launch, strb.complete}) <= 1); // R10

endmodule

// File: rtl/byte_word_bridge.sv
module byte_word_bridge
  import bwb_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapPolarity,
  input  logic              strapTrigger,
  input  logic              strapZeroWait,
  input  logic              hostStrobe,
  input  logic              hostWrite,
  input  logic              hostByteSel,
  input  logic [ADDR_W-1:0] hostWordAddr,
  input  logic [BYTE_W-1:0] hostWrData,
  output logic [BYTE_W-1:0] hostRdData,
  output logic              hostAck,
  output logic              intReq,
  output logic              intWrite,
  output logic [ADDR_W-1:0] intAddr,
  output logic [WORD_W-1:0] intWrData,
  input  logic [WORD_W-1:0] intRdData,
  input  logic              intReady
);

  bwb_strobe_t strb;
  logic        laneUpper;
  logic        launches;

  bwb_lane_decode uDecode (
    .strapPolarity (strapPolarity),
    .strapTrigger  (strapTrigger),
    .strapZeroWait (strapZeroWait),
    .hostByteSel   (hostByteSel),
    .hostWrite     (hostWrite),
    .laneUpper     (laneUpper),
    .launches      (launches)
  );

  bwb_ctrl uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .strapZeroWait (strapZeroWait),
    .hostStrobe    (hostStrobe),
    .hostWrite     (hostWrite),
    .launches      (launches),
    .intReady      (intReady),
    .strb          (strb),
    .intReq        (intReq),
    .hostAck       (hostAck)
  );

  bwb_datapath #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .laneUpper    (laneUpper),
    .hostWrite    (hostWrite),
    .hostWordAddr (hostWordAddr),
    .hostWrData   (hostWrData),
    .intRdData    (intRdData),
    .hostRdData   (hostRdData),
    .intAddr      (intAddr),
    .intWrite     (intWrite),
    .intWrData    (intWrData)
  );

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    intReq && !intReady |=> $stable(intAddr) && $stable(intWrData) && $stable(intWrite)); // R7

endmodule

// File: tb/byte_word_bridge_test.sv
module byte_word_bridge_test;

  localparam int ADDR_W = 14;

  typedef struct packed {
    logic       zw;
    logic       trig;
    logic       pol;
    logic       wr;
    logic       sel;
    logic [3:0] addr;
    logic [7:0] data;
    logic       expLaunch;
  } vec_t;

  // Expected launch flag derived by hand from R1..R3
  localparam vec_t VEC [0:17] = '{
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'h3, 8'hA5, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'h3, 8'h3C, 1'b1},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'h3, 8'h00, 1'b1},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'h3, 8'h00, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'h5, 8'h11, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'h5, 8'hE2, 1'b1},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h5, 8'h00, 1'b1},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'h5, 8'h00, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h9, 8'h7F, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h9, 8'h80, 1'b1},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h9, 8'h00, 1'b1},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'h9, 8'h00, 1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hC, 8'h4D, 1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'hC, 8'hB6, 1'b1},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'hC, 8'h00, 1'b1},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hC, 8'h00, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'h5, 8'h00, 1'b1},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h5, 8'h00, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              strapPolarity = 1'b0;
  logic              strapTrigger = 1'b0;
  logic              strapZeroWait = 1'b1;
  logic              hostStrobe = 1'b0;
  logic              hostWrite = 1'b0;
  logic              hostByteSel = 1'b0;
  logic [ADDR_W-1:0] hostWordAddr = '0;
  logic [7:0]        hostWrData = '0;
  logic [7:0]        hostRdData;
  logic              hostAck;
  logic              intReq;
  logic              intWrite;
  logic [ADDR_W-1:0] intAddr;
  logic [15:0]       intWrData;
  logic [15:0]       intRdData = '0;
  logic              intReady = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0]       mem [16];
  int                respDelay = 0;
  int                respCnt = 0;
  int                cycleCount = 0;
  int                ackCount = 0;
  logic [15:0]       lastWrWord = '0;
  logic [ADDR_W-1:0] lastWrAddr = '0;

  always #2.5 clk = ~clk;

  byte_word_bridge #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN),
    .strapPolarity(strapPolarity), .strapTrigger(strapTrigger), .strapZeroWait(strapZeroWait),
    .hostStrobe(hostStrobe), .hostWrite(hostWrite), .hostByteSel(hostByteSel),
    .hostWordAddr(hostWordAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .hostAck(hostAck), .intReq(intReq), .intWrite(intWrite), .intAddr(intAddr),
    .intWrData(intWrData), .intRdData(intRdData), .intReady(intReady)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doAccess(input logic wr, input logic sel, input logic [3:0] a,
                          input logic [7:0] d, output int waits, output logic [7:0] rd);
    @(negedge clk);
    hostStrobe = 1'b1; hostWrite = wr; hostByteSel = sel;
    hostWordAddr = ADDR_W'(a); hostWrData = d;
    @(negedge clk);
    hostStrobe = 1'b0;
    waits = 0;
    while (!(strapZeroWait ? !intReq : hostAck) && waits < 50) begin
      @(negedge clk);
      waits++;
    end
    rd = hostRdData;
    @(negedge clk);
  endtask

  // Internal memory responder and acknowledge monitor
  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'h0000;
    fork
      forever begin
        @(negedge clk);
        if (!rstN) begin
          intReady = 1'b0; respCnt = 0;
        end else if (intReady) begin
          intReady = 1'b0;
        end else if (intReq) begin
          if (respCnt >= respDelay) begin
            intReady = 1'b1; respCnt = 0;
            intRdData = mem[intAddr[3:0]];
            cycleCount++;
            if (intWrite) begin
              mem[intAddr[3:0]] = intWrData;
              lastWrWord = intWrData;
              lastWrAddr = intAddr;
            end
          end else begin
            respCnt++;
          end
        end
        if (hostAck) ackCount++;
      end
    join_none
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] holdM;
    logic [7:0] bufM;
    logic [7:0] rd;
    logic [15:0] expWord;
    logic [7:0] expRd;
    logic up;
    int waits;
    int c0;
    int a0;

    holdM = 8'h00; bufM = 8'h00;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 ack in reset", 32'(hostAck), 0);
    chk("R11 req in reset", 32'(intReq), 0);
    chk("R11 rddata in reset", 32'(hostRdData), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: R1..R6, R8, R9
    for (int v = 0; v < 18; v++) begin
      strapZeroWait = VEC[v].zw; strapTrigger = VEC[v].trig; strapPolarity = VEC[v].pol;
      respDelay = v % 3;
      c0 = cycleCount; a0 = ackCount;
      doAccess(VEC[v].wr, VEC[v].sel, VEC[v].addr, VEC[v].data, waits, rd);
      up = VEC[v].pol ? ~VEC[v].sel : VEC[v].sel;  // R1
      chk(VEC[v].zw ? "R2 launch select" : "R3 launch select",
          32'(cycleCount - c0), 32'(VEC[v].expLaunch));
      if (VEC[v].wr) begin
        if (VEC[v].expLaunch) begin
          expWord = up ? {VEC[v].data, holdM} : {holdM, VEC[v].data};
          chk("R4 merged word", 32'(lastWrWord), 32'(expWord));
          chk("R4 write addr", 32'(lastWrAddr), 32'(VEC[v].addr));
        end else begin
          holdM = VEC[v].data;
        end
      end else begin
        if (VEC[v].expLaunch) begin
          expRd = up ? mem[VEC[v].addr][15:8] : mem[VEC[v].addr][7:0];
          bufM  = up ? mem[VEC[v].addr][7:0] : mem[VEC[v].addr][15:8];
          chk("R5 launched read byte", 32'(rd), 32'(expRd));
        end else begin
          chk("R6 buffered read byte", 32'(rd), 32'(bufM));
        end
      end
      if (VEC[v].zw) begin
        chk("R8 ack latency", 32'(waits), VEC[v].expLaunch ? 32'(respDelay + 1) : 0);
        chk("R8 single ack", 32'(ackCount - a0), 1);
      end else begin
        chk("R9 no ack zero-wait", 32'(ackCount - a0), 0);
      end
    end

    // R7 / R10: strobe during a pending write is ignored
    strapZeroWait = 1'b1; strapTrigger = 1'b1; strapPolarity = 1'b1;
    respDelay = 0;
    doAccess(1'b1, 1'b0, 4'h2, 8'h12, waits, rd);   // upper byte held
    respDelay = 6;
    c0 = cycleCount; a0 = ackCount;
    @(negedge clk);
    hostStrobe = 1'b1; hostWrite = 1'b1; hostByteSel = 1'b1;
    hostWordAddr = ADDR_W'(2); hostWrData = 8'h56;
    @(negedge clk);
    hostStrobe = 1'b0;
    @(negedge clk);
    chk("R7 req held while not ready", 32'(intReq), 1);
    hostStrobe = 1'b1; hostByteSel = 1'b0; hostWrData = 8'hFF;  // would overwrite hold
    @(negedge clk);
    hostStrobe = 1'b0;
    chk("R7 req still held", 32'(intReq), 1);
    for (int w = 0; w < 20 && intReq; w++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R7 req dropped after ready", 32'(intReq), 0);
    chk("R10 one internal cycle", 32'(cycleCount - c0), 1);
    chk("R10 one ack", 32'(ackCount - a0), 1);
    chk("R4 merged word with hold", 32'(lastWrWord), 32'h1256);
    respDelay = 0;
    doAccess(1'b1, 1'b1, 4'h2, 8'h78, waits, rd);
    chk("R10 hold unchanged by ignored strobe", 32'(lastWrWord), 32'h1278);

    // R11: reset during a pending read
    respDelay = 20;
    @(negedge clk);
    hostStrobe = 1'b1; hostWrite = 1'b0; hostByteSel = 1'b0; hostWordAddr = ADDR_W'(3);
    @(negedge clk);
    hostStrobe = 1'b0;
    @(negedge clk);
    chk("R11 read pending before reset", 32'(intReq), 1);
    rstN = 1'b0;
    @(negedge clk);
    chk("R11 req cleared", 32'(intReq), 0);
    chk("R11 ack cleared", 32'(hostAck), 0);
    chk("R11 rddata cleared", 32'(hostRdData), 0);
    rstN = 1'b1;
    respDelay = 0;
    @(negedge clk);
    c0 = cycleCount;
    doAccess(1'b0, 1'b1, 4'h3, 8'h00, waits, rd);
    chk("R11 read buffer cleared", 32'(rd), 0);
    chk("R6 no internal cycle", 32'(cycleCount - c0), 0);
    doAccess(1'b1, 1'b1, 4'h4, 8'h9A, waits, rd);
    chk("R11 hold cleared", 32'(lastWrWord), 32'h009A);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule